// File: doc/BRIEF.md
# Daisy-Chained Soft-Configured Nibble Bus Peripheral

This block is a small nibble-wide memory peripheral that sits on a 4-bit serial-address processor bus. After reset it owns no address space. Startup software gives it a place in the map. Software first shifts a 20-bit address into the bus pointer, five nibbles with the least significant first. It then issues a configure command. Only the one device whose chain input is high and which is still unconfigured takes that address as its base. It then raises its chain output, which hands configuration rights to the next device on the chain. Before configuring, software can read a five-nibble identifier from the eligible device; the identifier carries the device size.

Once configured, the device answers ordinary reads and writes by address alone. The chain input plays no part in that decision. A read or write moves the shared pointer up by one nibble whether or not it hits, so bursts need no new address. An unconfigure command pointed inside the device's own range returns it to the unaddressed state. A build-time parameter selects a hard-wired variant instead. That variant is always configured, sits at a fixed base, and passes its chain input straight through to its chain output.

Command codes on `cmd`: 0 idle, 1 pointer load, 2 configure, 3 read-ID, 4 unconfigure, 5 read, 6 write.

Top module: `nib_cfg_periph`

## Requirements
- R1: After reset the device is unconfigured, `daisyOut` is 0 and `outValid` is 0; an unconfigured device never raises `outValid` except for an accepted read-ID.
- R2: A configure command (code 2) is taken only when `daisyIn` is 1 and the device is unconfigured. The base becomes the pointer with its low DEPTH_LOG2 bits cleared, and `daisyOut` is 1 from the next cycle on. With `daisyIn` at 0 the command leaves the device unconfigured.
- R3: A read-ID command (code 3), taken under the same conditions as configure, returns the next identifier nibble on `busOut` with `outValid` one cycle later. The identifier is 0x7B204 by default (tag 0x7B2, low byte DEPTH_LOG2) and is returned least significant nibble first: 4,0,2,B,7. With `daisyIn` at 0 no response appears.
- R4: A pointer-load command (code 1) shifts `busIn` into the top nibble of the pointer, so five loads leave the first nibble in bits 3:0. A load also restarts the identifier sequence.
- R5: A configured device whose pointer satisfies (pointer & ~(2^DEPTH_LOG2-1)) == base executes a write (code 6) into nibble RAM offset pointer[DEPTH_LOG2-1:0]. On a read (code 5) it returns that nibble with `outValid` one cycle later. `daisyIn` has no effect on this.
- R6: A read or write whose address lies outside the range gives no response and leaves the stored nibbles unchanged.
- R7: Every read or write command moves the pointer up by one, whether it hits or misses.
- R8: An unconfigure command (code 4) clears the device only when it is configured and the pointer is in range, after which `daisyOut` is 0 on the next cycle and reads no longer answer. Out of range it has no effect.
- R9: A configured soft device ignores further configure and read-ID commands: it keeps its base and gives no identifier response.
- R10: With HARD_CONFIG=1 the device answers reads and writes at FIXED_BASE from reset, `daisyOut` equals `daisyIn` at all times, and configure and unconfigure have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmd | input | 3 | Command code |
| busIn | input | 4 | Nibble from the processor (address or write data) |
| daisyIn | input | 1 | Configuration chain input |
| busOut | output | 4 | Response nibble (read data or identifier) |
| outValid | output | 1 | `busOut` holds a response |
| daisyOut | output | 1 | Configuration chain output to the next device |

## Verification
Reads and identifier reads are due on the cycle after the command edge. The bench pushes the expected nibble into a queue when it drives the command, and a monitor pops it 2 ns after the following rising edge. A response that appears with an empty queue, or a queue left non-empty at a phase boundary, counts as a failure, so missing and extra responses are both caught. `daisyOut` changes are checked at that same point one edge after configure or unconfigure. The hard-wired variant's `daisyOut` is combinational and is checked in the same cycle `daisyIn` is changed.

// File: rtl/nib_cfg_pkg.sv
package nib_cfg_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE   = 3'd0,
    CMD_LOAD   = 3'd1,
    CMD_CONFIG = 3'd2,
    CMD_READID = 3'd3,
    CMD_UNCFG  = 3'd4,
    CMD_READ   = 3'd5,
    CMD_WRITE  = 3'd6
  } busCmd_e;

  typedef struct packed {
    logic loadNib;
    logic setBase;
    logic idEn;
    logic rdEn;
    logic wrEn;
    logic advance;
  } ctlStrobes_t;

endpackage

// File: rtl/nib_cfg_ctrl.sv
module nib_cfg_ctrl
  import nib_cfg_pkg::*;
#(
  parameter bit HARD_CONFIG = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmd,
  input  logic        daisyIn,
  input  logic        addrHit,
  output ctlStrobes_t strobes,
  output logic        isConfigured,
  output logic        daisyOut
);

  busCmd_e cmdE;
  logic    eligible;
  logic    hit;

  assign cmdE = busCmd_e'(cmd);
  assign hit  = isConfigured && addrHit;

  generate
    if (HARD_CONFIG) begin : g_hard
      assign isConfigured = 1'b1;
      assign eligible     = 1'b0;
      assign daisyOut     = daisyIn;
    end else begin : g_soft
      logic cfgQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cfgQ <= 1'b0;
        end else if (cmdValid && cmdE == CMD_CONFIG && daisyIn && !cfgQ) begin
          cfgQ <= 1'b1;
        end else if (cmdValid && cmdE == CMD_UNCFG && cfgQ && addrHit) begin
          cfgQ <= 1'b0;
        end
      end
      assign isConfigured = cfgQ;
      assign eligible     = daisyIn && !cfgQ;
      assign daisyOut     = cfgQ;
    end
  endgenerate

  always_comb begin
    strobes         = '0;
    strobes.loadNib = cmdValid && cmdE == CMD_LOAD;
    strobes.setBase = cmdValid && cmdE == CMD_CONFIG && eligible;
    strobes.idEn    = cmdValid && cmdE == CMD_READID && eligible;
    strobes.rdEn    = cmdValid && cmdE == CMD_READ && hit;
    strobes.wrEn    = cmdValid && cmdE == CMD_WRITE && hit;
    strobes.advance = cmdValid && (cmdE == CMD_READ || cmdE == CMD_WRITE);
  end

endmodule

// File: rtl/nib_cfg_dpath.sv
module nib_cfg_dpath
  import nib_cfg_pkg::*;
#(
  parameter int                ADDR_W      = 20,
  parameter int                NIB_W       = 4,
  parameter int                DEPTH_LOG2  = 4,
  parameter logic [ADDR_W-9:0] ID_TAG      = 12'h7B2,
  parameter bit                HARD_CONFIG = 1'b0,
  parameter logic [ADDR_W-1:0] FIXED_BASE  = 20'h00040
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [NIB_W-1:0]  busIn,
  output logic              addrHit,
  output logic [ADDR_W-1:0] curPtr,
  output logic [NIB_W-1:0]  busOut,
  output logic              outValid
);

  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int DEPTH     = 1 << DEPTH_LOG2;
  localparam int IDX_W     = $clog2(ADDR_NIBS);
  localparam logic [ADDR_W-1:0] SIZE_MASK  = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] DEV_ID     = {ID_TAG, 8'(DEPTH_LOG2)};
  localparam logic [ADDR_W-1:0] RESET_BASE = HARD_CONFIG ? (FIXED_BASE & ~SIZE_MASK) : '0;

  logic [ADDR_W-1:0]     ptrQ;
  logic [ADDR_W-1:0]     baseQ;
  logic [IDX_W-1:0]      idIdx;
  logic [NIB_W-1:0]      mem [DEPTH];
  logic [DEPTH_LOG2-1:0] offset;
  logic [NIB_W-1:0]      idNib;

  assign curPtr  = ptrQ;
  assign offset  = ptrQ[DEPTH_LOG2-1:0];
  assign addrHit = (ptrQ & ~SIZE_MASK) == baseQ;
  assign idNib   = DEV_ID[idIdx*NIB_W +: NIB_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (strobes.loadNib) begin
      ptrQ <= {busIn, ptrQ[ADDR_W-1:NIB_W]};
    end else if (strobes.advance) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= RESET_BASE;
    end else if (strobes.setBase) begin
      baseQ <= ptrQ & ~SIZE_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.loadNib) begin
      idIdx <= '0;
    end else if (strobes.idEn) begin
      idIdx <= (idIdx == IDX_W'(ADDR_NIBS - 1)) ? '0 : idIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.wrEn) begin
      mem[offset] <= busIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      busOut   <= '0;
    end else begin
      outValid <= strobes.rdEn || strobes.idEn;
      if (strobes.rdEn) begin
        busOut <= mem[offset];
      end else if (strobes.idEn) begin
        busOut <= idNib;
      end
    end
  end

endmodule

// File: rtl/nib_cfg_periph.sv
module nib_cfg_periph
  import nib_cfg_pkg::*;
#(
  parameter int          ADDR_W      = 20,
  parameter int          NIB_W       = 4,
  parameter int          DEPTH_LOG2  = 4,
  parameter logic [11:0] ID_TAG      = 12'h7B2,
  parameter bit          HARD_CONFIG = 1'b0,
  parameter logic [19:0] FIXED_BASE  = 20'h00040
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmd,
  input  logic [NIB_W-1:0] busIn,
  input  logic             daisyIn,
  output logic [NIB_W-1:0] busOut,
  output logic             outValid,
  output logic             daisyOut
);

  ctlStrobes_t       strobes;
  logic              addrHit;
  logic              isConfigured;
  logic [ADDR_W-1:0] curPtr;

  nib_cfg_ctrl #(.HARD_CONFIG(HARD_CONFIG)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmd(cmd),
    .daisyIn(daisyIn), .addrHit(addrHit), .strobes(strobes),
    .isConfigured(isConfigured), .daisyOut(daisyOut)
  );

  nib_cfg_dpath #(
    .ADDR_W(ADDR_W), .NIB_W(NIB_W), .DEPTH_LOG2(DEPTH_LOG2),
    .ID_TAG(ID_TAG), .HARD_CONFIG(HARD_CONFIG), .FIXED_BASE(FIXED_BASE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busIn(busIn),
    .addrHit(addrHit), .curPtr(curPtr), .busOut(busOut), .outValid(outValid)
  );

endmodule

// File: rtl/nib_cfg_checker.sv
module nib_cfg_checker #(
  parameter int ADDR_W      = 20,
  parameter bit HARD_CONFIG = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [2:0]        cmd,
  input logic              daisyIn,
  input logic              daisyOut,
  input logic              outValid,
  input logic              isConfigured,
  input logic              addrHit,
  input logic [ADDR_W-1:0] curPtr
);

  // R7: pointer moves up by one after every read or write command
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmd == 3'd5 || cmd == 3'd6)) |=> curPtr == $past(curPtr) + 1'b1);

  generate
    if (HARD_CONFIG) begin : g_hard
      // R10: chain passes straight through
      a_r10_daisy_pass: assert property (@(posedge clk) disable iff (!rstN)
        daisyOut == daisyIn);
      // R10: in-range read always answers
      a_r10_read_answers: assert property (@(posedge clk) disable iff (!rstN)
        (cmdValid && cmd == 3'd5 && addrHit) |=> outValid);
    end else begin : g_soft
      // R1: unconfigured device is silent apart from read-ID
      a_r1_quiet_unconf: assert property (@(posedge clk) disable iff (!rstN)
        (!isConfigured && !(cmdValid && cmd == 3'd3)) |=> !outValid);
      // R2: configure without chain input is refused
      a_r2_cfg_needs_chain: assert property (@(posedge clk) disable iff (!rstN)
        (cmdValid && cmd == 3'd2 && !daisyIn && !isConfigured) |=> !isConfigured);
      // R2: accepted configure raises chain output
      a_r2_cfg_raises_out: assert property (@(posedge clk) disable iff (!rstN)
        (cmdValid && cmd == 3'd2 && daisyIn && !isConfigured) |=> daisyOut);
      // R8: in-range unconfigure drops chain output
      a_r8_uncfg_drops: assert property (@(posedge clk) disable iff (!rstN)
        (cmdValid && cmd == 3'd4 && isConfigured && addrHit) |=> !daisyOut);
      // R9: configured device gives no identifier
      a_r9_no_id_after_cfg: assert property (@(posedge clk) disable iff (!rstN)
        (isConfigured && cmdValid && cmd == 3'd3) |=> !outValid);
      // R5: in-range read answers regardless of chain input
      a_r5_read_answers: assert property (@(posedge clk) disable iff (!rstN)
        (isConfigured && cmdValid && cmd == 3'd5 && addrHit) |=> outValid);
    end
  endgenerate

endmodule

bind nib_cfg_periph nib_cfg_checker #(.ADDR_W(ADDR_W), .HARD_CONFIG(HARD_CONFIG)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmd(cmd), .daisyIn(daisyIn),
  .daisyOut(daisyOut), .outValid(outValid), .isConfigured(isConfigured),
  .addrHit(addrHit), .curPtr(curPtr)
);

// File: tb/tb_nib_cfg_periph.sv
`timescale 1ns/1ps
module tb_nib_cfg_periph;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [3:0] busIn = 4'd0;
  logic       daisyIn = 1'b0;
  logic [3:0] busOut, hOut;
  logic       outValid, hValid, daisyOut, hDaisy;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [3:0] expQ[$];

  always #4 clk = ~clk;

  nib_cfg_periph dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmd(cmd), .busIn(busIn),
    .daisyIn(daisyIn), .busOut(busOut), .outValid(outValid), .daisyOut(daisyOut)
  );

  nib_cfg_periph #(.HARD_CONFIG(1'b1), .FIXED_BASE(20'h00040)) dutHard (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmd(cmd), .busIn(busIn),
    .daisyIn(daisyIn), .busOut(hOut), .outValid(hValid), .daisyOut(hDaisy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one command; returns 2 ns after the edge that takes it
  task automatic issue(input logic [2:0] c, input logic [3:0] d);
    @(negedge clk);
    cmd = c; busIn = d; cmdValid = 1'b1;
    @(posedge clk);
    #1 cmdValid = 1'b0;
    #1;
  endtask

  task automatic issueExp(input logic [2:0] c, input logic [3:0] d, input logic [3:0] e);
    expQ.push_back(e);
    issue(c, d);
  endtask

  task automatic loadAddr(input logic [19:0] a);
    for (int i = 0; i < 5; i++) issue(3'd1, a[i*4 +: 4]);
  endtask

  // scoreboard monitor for the soft device
  always @(posedge clk) begin
    #2;
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        checks++; errs++;
        $display("FAIL R6: unexpected response actual=%0h expected=none", busOut);
      end else begin
        chk("R5 response", busOut, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 daisyOut", daisyOut, 0);
    chk("R1 outValid", outValid, 0);
    @(negedge clk) rstN = 1'b1;

    // R3 / R2: chain input low -> ignored
    daisyIn = 1'b0;
    loadAddr(20'h12345);
    issue(3'd3, 4'd0);
    issue(3'd2, 4'd0);
    issue(3'd0, 4'd0);
    chk("R2 refused without chain", daisyOut, 0);
    chk("R3 no id without chain", expQ.size(), 0);

    // R3 / R4: identifier nibbles, least significant first
    @(negedge clk) daisyIn = 1'b1;
    loadAddr(20'h12345);
    issueExp(3'd3, 0, 4'h4);
    issueExp(3'd3, 0, 4'h0);
    issueExp(3'd3, 0, 4'h2);
    issueExp(3'd3, 0, 4'hB);
    issueExp(3'd3, 0, 4'h7);
    issue(3'd0, 0);
    chk("R3 id stream drained", expQ.size(), 0);

    // R2: configure at 0x12345 -> base 0x12340
    issue(3'd2, 0);
    chk("R2 daisyOut after cfg", daisyOut, 1);

    // R9: configured -> no id, second configure ignored
    issue(3'd3, 0);
    loadAddr(20'h55550);
    issue(3'd2, 0);
    issue(3'd0, 0);
    chk("R9 no id when configured", expQ.size(), 0);

    // R5 / R7: burst write and read back, chain input low
    @(negedge clk) daisyIn = 1'b0;
    loadAddr(20'h12340);
    for (int i = 0; i < 16; i++) issue(3'd6, 4'(i * 3 + 1));
    loadAddr(20'h12340);
    for (int i = 0; i < 16; i++) issueExp(3'd5, 0, 4'(i * 3 + 1));
    issue(3'd0, 0);
    chk("R5 burst drained", expQ.size(), 0);

    // R6: miss write does not disturb offset 0
    loadAddr(20'h12350);
    issue(3'd6, 4'hF);
    issue(3'd5, 0);
    issue(3'd0, 0);
    loadAddr(20'h12340);
    issueExp(3'd5, 0, 4'h1);
    issue(3'd0, 0);
    chk("R6 miss silent", expQ.size(), 0);

    // R7: a miss read still advances into the range
    loadAddr(20'h1233F);
    issue(3'd5, 0);
    issueExp(3'd5, 0, 4'h1);
    issueExp(3'd5, 0, 4'h4);
    issue(3'd0, 0);
    chk("R7 advance on miss", expQ.size(), 0);

    // R8: unconfigure out of range ignored, in range honoured
    loadAddr(20'h00000);
    issue(3'd4, 0);
    chk("R8 out-of-range uncfg ignored", daisyOut, 1);
    loadAddr(20'h12347);
    issue(3'd4, 0);
    chk("R8 uncfg clears daisyOut", daisyOut, 0);
    loadAddr(20'h12340);
    issue(3'd5, 0);
    issue(3'd0, 0);
    chk("R8 silent after uncfg", expQ.size(), 0);

    // R10: hard-wired variant
    @(negedge clk) daisyIn = 1'b1;
    #1 chk("R10 daisy pass high", hDaisy, 1);
    @(negedge clk) daisyIn = 1'b0;
    #1 chk("R10 daisy pass low", hDaisy, 0);
    loadAddr(20'h00043);
    issue(3'd6, 4'h9);
    loadAddr(20'h00043);
    issue(3'd5, 0);
    chk("R10 hard read valid", hValid, 1);
    chk("R10 hard read data", hOut, 4'h9);
    @(negedge clk) daisyIn = 1'b1;
    loadAddr(20'h99990);
    issue(3'd2, 0);
    loadAddr(20'h00043);
    issue(3'd4, 0);
    issue(3'd5, 0);
    chk("R10 hard survives cfg/uncfg", hValid, 1);
    chk("R10 hard data kept", hOut, 4'h9);
    issue(3'd0, 0);
    chk("R6 soft silent at other range", expQ.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule